// File: doc/BRIEF.md
# Aggregated PHY Status Word

This block holds one 16-bit read-only word of an Ethernet PHY management register file. It collects the status that software most often needs in one place: the crossover state, link, speed, duplex, loopback and auto-negotiation completion, plus event flags for receive errors, false carrier, polarity inversion, page reception, pending interrupts and remote faults. Two more bits track the health of the 100BASE-TX receive path: signal detect and descrambler lock.

Live levels are registered once per clock. Event pulses set sticky bits. A sticky bit returns to 0 only when its owning companion register is read, which the block sees as a one-cycle read strobe. A read of this word therefore leaves all latch-high bits alone. It only re-arms the two latch-low bits. Reset clears the whole word. When a setting condition and a clearing read fall in the same cycle, the setting condition wins. A read presents the word as it stood before that cycle's update.

Top module: `phy_status_word`

## Requirements
- R1: Bit 15 is reserved and always reads 0.
- R2: Bits 14 (crossover, 1 = pairs swapped), 5 (jabber), 4 (auto-negotiation done), 3 (loopback), 2 (duplex, 1 = full), 1 (speed, 1 = 10 Mbps) and 0 (link valid) show the value their input had at the previous rising clock edge.
- R3: Bit 13 sets after a receive error pulse and holds until a receive-error-counter read strobe clears it.
- R4: Bit 11 sets after a false carrier pulse and holds until a false-carrier-counter read strobe clears it.
- R5: Bit 12 sets after an inverted-polarity pulse and holds until a 10BASE-T status read strobe clears it.
- R6: Bit 8 sets after a page-received pulse and holds until an auto-negotiation expansion read strobe clears it.
- R7: Bit 7 sets after an interrupt pulse and holds until an interrupt status read strobe clears it.
- R8: Bit 6 sets after a remote fault pulse and holds until a basic status read strobe clears it.
- R9: Bits 10 (signal detect) and 9 (descrambler lock) are latch-low. After any cycle with the source low, the bit reads 0 and stays 0 until a read of this word. A read sets the bit to the source level of that cycle.
- R10: When a setting condition and a clearing read occur in the same cycle, the bit ends the cycle at its set value (1 for latch-high, 0 for latch-low).
- R11: While reset is asserted, all 16 bits read 0, including both latch-low bits.
- R12: A read of this word changes none of the latch-high bits 13, 12, 11, 8, 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xover_swapped | input | 1 | Live crossover state, 1 = pairs swapped |
| jabber | input | 1 | Live jabber condition |
| an_done | input | 1 | Live auto-negotiation complete |
| loopback | input | 1 | Live loopback enable |
| full_duplex | input | 1 | Live duplex, 1 = full |
| speed_10 | input | 1 | Live speed, 1 = 10 Mbps |
| link_up | input | 1 | Live link valid |
| sig_det | input | 1 | Live 100BASE-TX signal detect |
| dscr_lock | input | 1 | Live descrambler lock |
| rx_err_evt | input | 1 | Receive error event pulse |
| false_carrier_evt | input | 1 | False carrier event pulse |
| pol_inv_evt | input | 1 | Inverted polarity event pulse |
| page_rx_evt | input | 1 | Link code word page received pulse |
| irq_evt | input | 1 | Interrupt raised pulse |
| rfault_evt | input | 1 | Remote fault pulse |
| rd_self | input | 1 | Read strobe for this word |
| rd_rxerr_cnt | input | 1 | Read strobe, receive error counter |
| rd_fc_cnt | input | 1 | Read strobe, false carrier counter |
| rd_tenbt_stat | input | 1 | Read strobe, 10BASE-T status register |
| rd_an_exp | input | 1 | Read strobe, auto-negotiation expansion register |
| rd_irq_stat | input | 1 | Read strobe, interrupt status register |
| rd_basic_stat | input | 1 | Read strobe, basic status register |
| rdata | output | 16 | Status word |

## Verification
Every bit of the word is registered. An input or strobe that is present at a rising edge shows on rdata from that edge on, one cycle later, and stays until the next edge. The bench changes inputs only on falling edges. It works out the expected word for the coming edge from the word it predicted before, and it compares on the next falling edge. Each sample therefore lands halfway through the cycle in which the result is due. Directed sequences cover simultaneous set and clear, reads of this word against latched events, and latch-low re-arm, all on the same one-cycle timing.

// File: rtl/phy_status_word.sv
module phy_status_word (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xover_swapped,
  input  logic        jabber,
  input  logic        an_done,
  input  logic        loopback,
  input  logic        full_duplex,
  input  logic        speed_10,
  input  logic        link_up,
  input  logic        sig_det,
  input  logic        dscr_lock,
  input  logic        rx_err_evt,
  input  logic        false_carrier_evt,
  input  logic        pol_inv_evt,
  input  logic        page_rx_evt,
  input  logic        irq_evt,
  input  logic        rfault_evt,
  input  logic        rd_self,
  input  logic        rd_rxerr_cnt,
  input  logic        rd_fc_cnt,
  input  logic        rd_tenbt_stat,
  input  logic        rd_an_exp,
  input  logic        rd_irq_stat,
  input  logic        rd_basic_stat,
  output logic [15:0] rdata
);

  logic [6:0] live_q;
  logic       rxerr_q, fc_q, pol_q, page_q, irq_q, rf_q;
  logic       sd_q, lock_q;

  logic [6:0] live_d;
  assign live_d = {xover_swapped, jabber, an_done, loopback,
                   full_duplex, speed_10, link_up};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= '0;
      rxerr_q <= 1'b0;
      fc_q    <= 1'b0;
      pol_q   <= 1'b0;
      page_q  <= 1'b0;
      irq_q   <= 1'b0;
      rf_q    <= 1'b0;
      sd_q    <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      live_q  <= live_d;
      rxerr_q <= rx_err_evt        | (rxerr_q & ~rd_rxerr_cnt);
      fc_q    <= false_carrier_evt | (fc_q    & ~rd_fc_cnt);
      pol_q   <= pol_inv_evt       | (pol_q   & ~rd_tenbt_stat);
      page_q  <= page_rx_evt       | (page_q  & ~rd_an_exp);
      irq_q   <= irq_evt           | (irq_q   & ~rd_irq_stat);
      rf_q    <= rfault_evt        | (rf_q    & ~rd_basic_stat);
      sd_q    <= sig_det   & (sd_q   | rd_self);
      lock_q  <= dscr_lock & (lock_q | rd_self);
    end
  end

  assign rdata = {1'b0, live_q[6], rxerr_q, pol_q, fc_q, sd_q, lock_q,
                  page_q, irq_q, rf_q, live_q[5:0]};

endmodule

module phy_status_word_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        sig_det,
  input logic        rx_err_evt,
  input logic        false_carrier_evt,
  input logic        irq_evt,
  input logic        rd_self,
  input logic        rd_rxerr_cnt,
  input logic        rd_fc_cnt,
  input logic        rd_irq_stat,
  input logic [15:0] rdata
);

  always @(negedge clk) if (rst_n) p_rsv_zero_r1: assert (rdata[15] == 1'b0);

  p_link_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rdata[0] == $past(link_up));

  p_rxerr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt |=> rdata[13]);

  p_rxerr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[13] && !rd_rxerr_cnt |=> rdata[13]);

  p_fc_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    false_carrier_evt && rd_fc_cnt |=> rdata[11]);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_irq_stat && !irq_evt |=> !rdata[7]);

  p_sd_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det |=> !rdata[10]);

  p_sd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[10] && !rd_self |=> !rdata[10]);

  p_self_read_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_self && rdata[11] && !rd_fc_cnt |=> rdata[11]);

endmodule

bind phy_status_word phy_status_word_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .sig_det(sig_det),
  .rx_err_evt(rx_err_evt), .false_carrier_evt(false_carrier_evt),
  .irq_evt(irq_evt), .rd_self(rd_self), .rd_rxerr_cnt(rd_rxerr_cnt),
  .rd_fc_cnt(rd_fc_cnt), .rd_irq_stat(rd_irq_stat), .rdata(rdata)
);

// File: tb/tb_phy_status_word.sv
`timescale 1ns/1ps
module tb_phy_status_word;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // live: {xover, jabber, an_done, loopback, full_duplex, speed_10, link_up}
  logic [6:0] live = '0;
  // ev: {rx_err, false_carrier, pol_inv, page_rx, irq, rfault}
  logic [5:0] ev = '0;
  logic sd = 1'b0, lk = 1'b0;
  // rd: {self, rxerr_cnt, fc_cnt, tenbt, an_exp, irq_stat, basic}
  logic [6:0] rd = '0;
  logic [15:0] rdata;
  logic [15:0] model = '0;

  int checks = 0;
  int fails = 0;

  phy_status_word dut (
    .clk(clk), .rst_n(rst_n),
    .xover_swapped(live[6]), .jabber(live[5]), .an_done(live[4]),
    .loopback(live[3]), .full_duplex(live[2]), .speed_10(live[1]),
    .link_up(live[0]), .sig_det(sd), .dscr_lock(lk),
    .rx_err_evt(ev[5]), .false_carrier_evt(ev[4]), .pol_inv_evt(ev[3]),
    .page_rx_evt(ev[2]), .irq_evt(ev[1]), .rfault_evt(ev[0]),
    .rd_self(rd[6]), .rd_rxerr_cnt(rd[5]), .rd_fc_cnt(rd[4]),
    .rd_tenbt_stat(rd[3]), .rd_an_exp(rd[2]), .rd_irq_stat(rd[1]),
    .rd_basic_stat(rd[0]), .rdata(rdata)
  );

  function automatic logic [15:0] predict(logic [15:0] q);
    logic [15:0] n;
    n[15] = 1'b0;
    n[14] = live[6];
    n[5:0] = {live[5:0]};
    n[13] = ev[5] | (q[13] & ~rd[5]);
    n[11] = ev[4] | (q[11] & ~rd[4]);
    n[12] = ev[3] | (q[12] & ~rd[3]);
    n[8]  = ev[2] | (q[8]  & ~rd[2]);
    n[7]  = ev[1] | (q[7]  & ~rd[1]);
    n[6]  = ev[0] | (q[6]  & ~rd[0]);
    n[10] = sd & (q[10] | rd[6]);
    n[9]  = lk & (q[9]  | rd[6]);
    return n;
  endfunction

  function automatic string req_of(int b);
    case (b)
      15: return "R1";
      13: return "R3";
      11: return "R4";
      12: return "R5";
      8:  return "R6";
      7:  return "R7";
      6:  return "R8";
      10, 9: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check_word(string tag);
    checks++;
    if (rdata !== model) begin
      fails++;
      for (int b = 15; b >= 0; b--)
        if (rdata[b] !== model[b]) begin
          $display("FAIL %s/%s bit %0d: actual %h expected %h", tag, req_of(b), b, rdata, model);
          break;
        end
    end
  endtask

  task automatic check_bit(int b, logic exp, string tag);
    checks++;
    if (rdata[b] !== exp) begin
      fails++;
      $display("FAIL %s bit %0d: actual %b expected %b", tag, b, rdata[b], exp);
    end
  endtask

  task automatic step(string tag);
    model = rst_n ? predict(model) : 16'h0;
    @(posedge clk);
    @(negedge clk);
    check_word(tag);
    ev = '0;
    rd = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // R11: reset with every source active
    live = '1; sd = 1; lk = 1; ev = '1;
    step("R11 reset");
    step("R11 reset");
    checks++;
    if (rdata !== 16'h0) begin
      fails++;
      $display("FAIL R11: actual %h expected 0000", rdata);
    end
    rst_n = 1'b1;
    live = 7'b1010101; sd = 1; lk = 1;
    step("R2 live");
    check_bit(10, 1'b0, "R9 latch-low stays 0 after reset until read");
    rd[6] = 1; step("R9 rearm");
    check_bit(10, 1'b1, "R9 rearm on read");
    check_bit(9, 1'b1, "R9 lock rearm on read");

    // R3 / R12: set, then read this word, then owner read
    ev[5] = 1; step("R3 set");
    check_bit(13, 1'b1, "R3 set");
    rd[6] = 1; step("R12 self read");
    check_bit(13, 1'b1, "R12 self read keeps rx err");
    rd[5] = 1; step("R3 clear");
    check_bit(13, 1'b0, "R3 clear by counter read");

    // R10: set and clear together
    ev[4] = 1; rd[4] = 1; step("R10 fc");
    check_bit(11, 1'b1, "R10 set wins fc");
    rd[4] = 1; step("R4 clear");
    check_bit(11, 1'b0, "R4 clear");

    // R9: drop for one cycle, source recovers, stays low until read
    sd = 0; step("R9 drop");
    sd = 1; step("R9 recover");
    check_bit(10, 1'b0, "R9 hold low");
    sd = 0; rd[6] = 1; step("R10 latch-low drop with read");
    check_bit(10, 1'b0, "R10 drop wins over read");
    sd = 1;

    // R5..R8 owner mismatch: a wrong read does not clear
    ev = 6'b001111; step("R5-8 set");
    rd = 7'b1110001; step("R5 R6 R7 cross reads");
    check_bit(12, 1'b1, "R5 kept");
    check_bit(8, 1'b1, "R6 kept");
    check_bit(7, 1'b1, "R7 kept");
    check_bit(6, 1'b0, "R8 cleared by basic read");
    rd = 7'b0001110; step("R5 R6 R7 clear");
    check_bit(12, 1'b0, "R5 cleared");
    check_bit(8, 1'b0, "R6 cleared");
    check_bit(7, 1'b0, "R7 cleared");

    // constrained random traffic
    for (int i = 0; i < 1500; i++) begin
      live = 7'($urandom);
      sd = ($urandom % 8) != 0;
      lk = ($urandom % 8) != 0;
      for (int k = 0; k < 6; k++) ev[k] = ($urandom % 10) == 0;
      for (int k = 0; k < 7; k++) rd[k] = ($urandom % 6) == 0;
      if (i == 700) rst_n = 1'b0;
      if (i == 703) rst_n = 1'b1;
      step("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule